// File: doc/BRIEF.md
# HDLC Receive Block Buffer

This block sits between a bit-level HDLC deframer and a host that drains received frames in blocks. Every byte of a frame is written into one of several ping-pong banks of `BLK` bytes. A bank goes to the host in one of two cases. When it fills in the middle of a frame, the block raises a block-ready event. When the frame ends, the block appends a status byte and raises a message-end event.

The host reads the oldest bank one byte at a time. A count register gives the number of bytes held in that bank, modulo `BLK`. The host then hands the bank back with a release command. A second command discards everything buffered. If bytes arrive while every bank is still held, they are dropped, an overflow event is raised, and the status byte of that frame records the loss. Events are collected in a clear-on-read status register. A per-event mask gates the interrupt line.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the event register reads 0, the interrupt line is low, all three events are masked (mask bits 7:5 = 1) and the count reads 0.
- R2: Frame bytes are read back in arrival order. `host_rdata` shows the byte at the read position of the oldest held bank, and a `host_rd` pulse advances that position by one.
- R3: When a bank fills with `BLK` bytes before the frame ends, event bit 6 (block ready) is set. The bank becomes readable, and the count for it reads 0, meaning a full `BLK`.
- R4: At frame end, a status byte is stored after the frame's last data byte and event bit 7 (message end) is set. The count reads (bytes in bank including the status byte) mod `BLK`. A status byte that lands in the last slot of a bank gives a count of 0 and sets only bit 7.
- R5: The status byte has bit 7 = valid frame, bit 6 = data lost to overflow, bit 5 = CRC good and bit 4 = aborted, with bits 3:0 = 0. A good frame therefore reads 0xA0.
- R6: Command bit 7 (release) frees the oldest held bank and moves the read side to the next held bank. When no bank is held, the command has no effect.
- R7: A data byte that arrives while the bank being written is still held is dropped and sets event bit 5 (overflow). The frame's status byte then carries bit 6. A status byte that cannot be stored is dropped, sets event bit 5, and clears the frame's loss flag.
- R8: Command bit 6 (receiver reset) discards all held and partly written banks and resets both pointers. It leaves the event register unchanged and wins over a release in the same write.
- R9: Reading the event register (`ist_rd`) clears it. An event that arrives in the same cycle as the read stays recorded.
- R10: `irq` is high while any event bit is set whose mask bit is 0. Masked events are still recorded, and a `mask_wr` loads bits 7:5 of the mask.
- R11: A frame longer than `BLK` continues in the next bank in ring order, and the host reads its pieces in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received data byte |
| rx_vld | input | 1 | Data byte strobe |
| rx_eof | input | 1 | Frame-end strobe, carries status flags, no data |
| rx_vfr | input | 1 | Frame valid flag, sampled with `rx_eof` |
| rx_crc_ok | input | 1 | CRC good flag, sampled with `rx_eof` |
| rx_abort | input | 1 | Frame aborted flag, sampled with `rx_eof` |
| host_rd | input | 1 | Advance the read position by one byte |
| host_rdata | output | 8 | Byte at the read position |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 2 | Command bits 7:6 (release, receiver reset) |
| ist_rd | input | 1 | Event register read strobe, clears it |
| ist_data | output | 8 | Event register, bits 7:5 used |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 3 | Mask bits 7:5 |
| rcnt | output | 5 | Byte count of the oldest bank, modulo `BLK` |
| irq | output | 1 | Interrupt line |

## Verification
The tests drive short frames that fit in one bank. The expected count comes from the data plus the status byte, which shows whether the status byte is appended at the right slot. Frames of `BLK-1` and `BLK+8` data bytes separate a block-ready hand-over from a message-end hand-over, and show the status byte falling exactly on the bank boundary. Keeping every bank held while bytes, and then the frame end, arrive checks the overflow event, the loss flag in the status byte, and recovery by release or by receiver reset. An event-register read placed in the same cycle as a frame end, and a release with nothing held, check the two orderings that a naive implementation gets wrong.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
  // event register bit positions
  localparam int unsigned EV_MSG  = 7;
  localparam int unsigned EV_BLK  = 6;
  localparam int unsigned EV_OVF  = 5;
  // status byte bit positions
  localparam int unsigned ST_VFR  = 7;
  localparam int unsigned ST_LOST = 6;
  localparam int unsigned ST_CRC  = 5;
  localparam int unsigned ST_ABT  = 4;
  // command bit index within cmd_data[7:6]
  localparam int unsigned CMD_REL = 7;
  localparam int unsigned CMD_RST = 6;
endpackage

// File: rtl/hrx_store.sv
module hrx_store #(
  parameter int unsigned BLK   = 32,
  parameter int unsigned NBANK = 2,
  localparam int unsigned AW   = $clog2(BLK * NBANK)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [BLK*NBANK];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hrx_writer.sv
module hrx_writer
  import hrx_pkg::*;
#(
  parameter int unsigned BLK   = 32,
  parameter int unsigned NBANK = 2,
  localparam int unsigned IW   = $clog2(BLK),
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [7:0]       rx_data,
  input  logic             rx_vld,
  input  logic             rx_eof,
  input  logic             rx_vfr,
  input  logic             rx_crc_ok,
  input  logic             rx_abort,
  input  logic [NBANK-1:0] bank_held,
  output logic             wr_en,
  output logic [BW-1:0]    wr_bank,
  output logic [IW-1:0]    wr_idx,
  output logic [7:0]       wr_data,
  output logic             hand_en,
  output logic [BW-1:0]    hand_bank,
  output logic [IW-1:0]    hand_cnt,
  output logic             ev_msg,
  output logic             ev_blk,
  output logic             ev_ovf
);
  logic [BW-1:0] wbank_q, wbank_d, wbank_nx;
  logic [IW-1:0] widx_q, widx_d;
  logic          lost_q, lost_d;
  logic          room;
  logic [7:0]    stat_byte;

  assign room      = !bank_held[wbank_q];
  assign wbank_nx  = (wbank_q == BW'(NBANK - 1)) ? '0 : wbank_q + BW'(1);
  assign wr_bank   = wbank_q;
  assign wr_idx    = widx_q;
  assign hand_bank = wbank_q;

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_VFR]  = rx_vfr;
    stat_byte[ST_LOST] = lost_q;
    stat_byte[ST_CRC]  = rx_crc_ok;
    stat_byte[ST_ABT]  = rx_abort;
  end

  always_comb begin
    wbank_d  = wbank_q;
    widx_d   = widx_q;
    lost_d   = lost_q;
    wr_en    = 1'b0;
    wr_data  = rx_data;
    hand_en  = 1'b0;
    hand_cnt = widx_q + IW'(1);
    ev_msg   = 1'b0;
    ev_blk   = 1'b0;
    ev_ovf   = 1'b0;
    if (flush) begin
      wbank_d = '0;
      widx_d  = '0;
      lost_d  = 1'b0;
    end else if (rx_eof) begin
      lost_d = 1'b0;
      if (room) begin
        wr_en   = 1'b1;
        wr_data = stat_byte;
        hand_en = 1'b1;
        ev_msg  = 1'b1;
        wbank_d = wbank_nx;
        widx_d  = '0;
      end else begin
        ev_ovf = 1'b1;
      end
    end else if (rx_vld) begin
      if (room) begin
        wr_en = 1'b1;
        if (widx_q == IW'(BLK - 1)) begin
          hand_en = 1'b1;
          ev_blk  = 1'b1;
          wbank_d = wbank_nx;
          widx_d  = '0;
        end else begin
          widx_d = widx_q + IW'(1);
        end
      end else begin
        ev_ovf = 1'b1;
        lost_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank_q <= '0;
      widx_q  <= '0;
      lost_q  <= 1'b0;
    end else begin
      wbank_q <= wbank_d;
      widx_q  <= widx_d;
      lost_q  <= lost_d;
    end
  end

  // R7
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !rx_eof && !flush && bank_held[wbank_q]) |=> lost_q);

  // R3
  block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blk |=> (widx_q == '0));
endmodule

// File: rtl/hrx_evreg.sv
module hrx_evreg
  import hrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_msg,
  input  logic       ev_blk,
  input  logic       ev_ovf,
  input  logic       ist_rd,
  input  logic       mask_wr,
  input  logic [2:0] mask_data,
  output logic [7:0] ist_data,
  output logic       irq
);
  logic [2:0] ist_q, ist_d, ev_vec;
  logic [2:0] mask_q, mask_d;

  assign ev_vec = {ev_msg, ev_blk, ev_ovf};

  always_comb begin
    ist_d  = (ist_rd ? 3'b000 : ist_q) | ev_vec;
    mask_d = mask_wr ? mask_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q  <= '0;
      mask_q <= '1;
    end else begin
      ist_q  <= ist_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    ist_data = '0;
    ist_data[EV_MSG] = ist_q[2];
    ist_data[EV_BLK] = ist_q[1];
    ist_data[EV_OVF] = ist_q[0];
  end

  assign irq = |(ist_q & ~mask_q);

  // R4
  msg_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_msg |=> ist_data[EV_MSG]);

  // R9
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_rd && (ev_vec == 3'b000)) |=> (ist_data == 8'h00));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hrx_pkg::*;
#(
  parameter int unsigned BLK   = 32,
  parameter int unsigned NBANK = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_vld,
  input  logic       rx_eof,
  input  logic       rx_vfr,
  input  logic       rx_crc_ok,
  input  logic       rx_abort,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       cmd_wr,
  input  logic [7:6] cmd_data,
  input  logic       ist_rd,
  output logic [7:0] ist_data,
  input  logic       mask_wr,
  input  logic [7:5] mask_data,
  output logic [$clog2(BLK)-1:0] rcnt,
  output logic       irq
);
  localparam int unsigned IW = $clog2(BLK);
  localparam int unsigned BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int unsigned AW = $clog2(BLK * NBANK);

  logic             wr_en, hand_en, ev_msg, ev_blk, ev_ovf;
  logic [BW-1:0]    wr_bank, hand_bank;
  logic [IW-1:0]    wr_idx, hand_cnt;
  logic [7:0]       wr_data;
  logic             rres, rmc;

  logic [NBANK-1:0] held_q, held_d, hit_hand, hit_rel;
  logic [IW-1:0]    cnt_q [NBANK];
  logic [BW-1:0]    rdbank_q, rdbank_d;
  logic [IW-1:0]    rdidx_q, rdidx_d;
  logic [AW-1:0]    wr_addr, rd_addr;

  assign rres = cmd_wr && cmd_data[CMD_RST];
  assign rmc  = cmd_wr && cmd_data[CMD_REL] && !rres && held_q[rdbank_q];

  hrx_writer #(.BLK(BLK), .NBANK(NBANK)) u_writer (
    .clk(clk), .rst_n(rst_n), .flush(rres),
    .rx_data(rx_data), .rx_vld(rx_vld), .rx_eof(rx_eof),
    .rx_vfr(rx_vfr), .rx_crc_ok(rx_crc_ok), .rx_abort(rx_abort),
    .bank_held(held_q),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
    .hand_en(hand_en), .hand_bank(hand_bank), .hand_cnt(hand_cnt),
    .ev_msg(ev_msg), .ev_blk(ev_blk), .ev_ovf(ev_ovf)
  );

  assign wr_addr = AW'(wr_bank) * AW'(BLK) + AW'(wr_idx);
  assign rd_addr = AW'(rdbank_q) * AW'(BLK) + AW'(rdidx_q);

  hrx_store #(.BLK(BLK), .NBANK(NBANK)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(host_rdata)
  );

  hrx_evreg u_evreg (
    .clk(clk), .rst_n(rst_n),
    .ev_msg(ev_msg), .ev_blk(ev_blk), .ev_ovf(ev_ovf),
    .ist_rd(ist_rd), .mask_wr(mask_wr), .mask_data(mask_data),
    .ist_data(ist_data), .irq(irq)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign hit_hand[b] = hand_en && (hand_bank == BW'(b));
    assign hit_rel[b]  = rmc && (rdbank_q == BW'(b));
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      if (rres)             held_d[b] = 1'b0;
      else if (hit_hand[b]) held_d[b] = 1'b1;
      else if (hit_rel[b])  held_d[b] = 1'b0;
      else                  held_d[b] = held_q[b];
    end
    rdbank_d = rdbank_q;
    rdidx_d  = rdidx_q;
    if (rres) begin
      rdbank_d = '0;
      rdidx_d  = '0;
    end else if (rmc) begin
      rdbank_d = (rdbank_q == BW'(NBANK - 1)) ? '0 : rdbank_q + BW'(1);
      rdidx_d  = '0;
    end else if (host_rd && held_q[rdbank_q]) begin
      rdidx_d = rdidx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      rdbank_q <= '0;
      rdidx_q  <= '0;
    end else begin
      held_q   <= held_d;
      rdbank_q <= rdbank_d;
      rdidx_q  <= rdidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) cnt_q[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (hit_hand[b]) cnt_q[b] <= hand_cnt;
      end
    end
  end

  assign rcnt = cnt_q[rdbank_q];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !held_q[wr_bank]);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rres |=> (held_q == '0));

  // R6
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmc && !hand_en) |=> ($countones(held_q) == $past($countones(held_q)) - 1));
endmodule

// File: tb/hdlc_rx_fifo_bench.sv
module hdlc_rx_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_data;
  logic       rx_vld, rx_eof, rx_vfr, rx_crc_ok, rx_abort;
  logic       host_rd;
  logic [7:0] host_rdata;
  logic       cmd_wr;
  logic [7:6] cmd_data;
  logic       ist_rd;
  logic [7:0] ist_data;
  logic       mask_wr;
  logic [7:5] mask_data;
  logic [4:0] rcnt;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hdlc_rx_fifo u_hdlc_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_vld(rx_vld),
    .rx_eof(rx_eof), .rx_vfr(rx_vfr), .rx_crc_ok(rx_crc_ok),
    .rx_abort(rx_abort), .host_rd(host_rd), .host_rdata(host_rdata),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .ist_rd(ist_rd),
    .ist_data(ist_data), .mask_wr(mask_wr), .mask_data(mask_data),
    .rcnt(rcnt), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data = b; rx_vld = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic send_eof(input logic v, input logic c, input logic a);
    rx_eof = 1'b1; rx_vfr = v; rx_crc_ok = c; rx_abort = a;
    @(negedge clk);
    rx_eof = 1'b0; rx_vfr = 1'b0; rx_crc_ok = 1'b0; rx_abort = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    b = host_rdata; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic command(input logic [7:6] c);
    cmd_data = c; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic read_ist(output logic [7:0] v);
    v = ist_data; ist_rd = 1'b1;
    @(negedge clk);
    ist_rd = 1'b0;
  endtask

  task automatic set_mask(input logic [7:5] m);
    mask_data = m; mask_wr = 1'b1;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 event reg", ist_data, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 count", rcnt, 0);
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R1 masked irq", irq, 0);
    set_mask(3'b000);
  endtask

  task automatic t_short();
    logic [7:0] b;
    chk("R10 irq after unmask", irq, 1);
    chk("R4 leftover count", rcnt, 1);
    read_byte(b);
    chk("R5 leftover status", b, 8'hA0);
    command(2'b10);
    read_ist(b);
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R4 msg end event", ist_data, 8'h80);
    chk("R10 irq", irq, 1);
    chk("R4 count", rcnt, 4);
    read_byte(b); chk("R2 byte0", b, 8'hA1);
    read_byte(b); chk("R2 byte1", b, 8'hA2);
    read_byte(b); chk("R2 byte2", b, 8'hA3);
    read_byte(b); chk("R5 good status", b, 8'hA0);
    read_ist(b);
    chk("R9 cleared", ist_data, 8'h00);
    chk("R10 irq low", irq, 0);
    command(2'b10);
  endtask

  task automatic t_long();
    logic [7:0] b;
    for (int i = 0; i < 40; i++) send_byte(8'(8'h10 + i));
    send_eof(1'b1, 1'b0, 1'b1);
    chk("R3 block+msg events", ist_data, 8'hC0);
    chk("R3 full count", rcnt, 0);
    for (int i = 0; i < 32; i++) begin
      read_byte(b); chk("R11 first bank", b, 8'h10 + i);
    end
    command(2'b10);
    chk("R11 second count", rcnt, 9);
    for (int i = 32; i < 40; i++) begin
      read_byte(b); chk("R11 second bank", b, 8'h10 + i);
    end
    read_byte(b); chk("R5 abort status", b, 8'h90);
    command(2'b10);
    read_ist(b);
  endtask

  task automatic t_exact();
    logic [7:0] b;
    for (int i = 0; i < 31; i++) send_byte(8'(8'h40 + i));
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R4 status in last slot event", ist_data, 8'h80);
    chk("R4 status in last slot count", rcnt, 0);
    for (int i = 0; i < 31; i++) begin
      read_byte(b); chk("R2 exact data", b, 8'h40 + i);
    end
    read_byte(b); chk("R4 last slot status", b, 8'hA0);
    command(2'b10);
    read_ist(b);
  endtask

  task automatic t_idle_release();
    logic [7:0] b;
    command(2'b10);
    send_byte(8'h55);
    send_eof(1'b0, 1'b1, 1'b0);
    chk("R6 idle release count", rcnt, 2);
    read_byte(b); chk("R6 idle release data", b, 8'h55);
    read_byte(b); chk("R5 invalid status", b, 8'h20);
    command(2'b10);
    read_ist(b);
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    for (int i = 0; i < 64; i++) send_byte(8'(i));
    for (int i = 0; i < 3; i++) send_byte(8'hEE);
    chk("R7 overflow event", ist_data, 8'h60);
    command(2'b10);
    chk("R6 next bank count", rcnt, 0);
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R7 events after recovery", ist_data, 8'hE0);
    for (int i = 32; i < 64; i++) begin
      read_byte(b); chk("R6 next bank data", b, i);
    end
    command(2'b10);
    chk("R7 status-only count", rcnt, 1);
    read_byte(b); chk("R7 lost flag in status", b, 8'hE0);
    command(2'b10);
    read_ist(b);
  endtask

  task automatic t_rres();
    logic [7:0] b;
    for (int i = 0; i < 64; i++) send_byte(8'(i));
    send_eof(1'b1, 1'b1, 1'b0);
    read_ist(b);
    chk("R7 dropped status event", b, 8'h60);
    send_eof(1'b1, 1'b1, 1'b0);
    read_ist(b);
    command(2'b11);
    chk("R8 event reg untouched", ist_data, 8'h00);
    send_byte(8'h77);
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R8 count after reset", rcnt, 2);
    read_byte(b); chk("R8 data after reset", b, 8'h77);
    read_byte(b); chk("R8 status after reset", b, 8'hA0);
    command(2'b10);
    read_ist(b);
  endtask

  task automatic t_mask();
    logic [7:0] b;
    set_mask(3'b100);
    send_byte(8'h12);
    send_eof(1'b1, 1'b1, 1'b0);
    chk("R10 masked event recorded", ist_data, 8'h80);
    chk("R10 masked irq", irq, 0);
    set_mask(3'b000);
    chk("R10 unmasked irq", irq, 1);
    read_ist(b);
    command(2'b10);
  endtask

  task automatic t_collision();
    logic [7:0] b;
    send_byte(8'h34);
    rx_eof = 1'b1; rx_vfr = 1'b1; rx_crc_ok = 1'b1; ist_rd = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0; rx_vfr = 1'b0; rx_crc_ok = 1'b0; ist_rd = 1'b0;
    chk("R9 event kept on read", ist_data, 8'h80);
    read_byte(b); chk("R2 collision data", b, 8'h34);
    command(2'b10);
    read_ist(b);
  endtask

  initial begin
    rst_n = 1'b0; rx_data = '0; rx_vld = 1'b0; rx_eof = 1'b0;
    rx_vfr = 1'b0; rx_crc_ok = 1'b0; rx_abort = 1'b0; host_rd = 1'b0;
    cmd_wr = 1'b0; cmd_data = '0; ist_rd = 1'b0; mask_wr = 1'b0;
    mask_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_exact();
    t_idle_release();
    t_overflow();
    t_rres();
    t_mask();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule